// File: doc/BRIEF.md
# Serial clock and chip-select generator

This block produces the serial clock and the single active-low device select for a quad-lane serial flash master. A 32-bit control word, written in one cycle, sets the clock ratio, the clock idle level, the capture phase, how the select line behaves and whether frames wait for an explicit start command. From the reference clock the block derives the serial clock, and it emits one-cycle capture and advance strobes that a separate shift register uses to take in and present bits.

A frame is `FRAME_BITS` serial clock periods long. It begins when the neighbouring queue reports pending data on `tx_avail`, the block is enabled and, in held-start mode, a start command has just been written. The ratio code selects a power-of-two division, so slow and fast clocks come from one small counter. A new ratio code is adopted only between frames while the select line is high, so the running frame keeps its timing.

Top module: `sclk_cs_gen`

## Requirements
- R1: After reset `sclk` is 0, `cs_n` is 1, and `active`, `launch`, `shift_stb`, `sample_stb` and `cfg_rdata` are all 0.
- R2: The control word fields are enable at bit 0, idle level at bit 1, phase at bit 2, ratio code at bits 5:3, select value at bit 10, select override at bit 14, held-start mode at bit 15 and start command at bit 16. Reads return every field except the start command, which always reads 0. All other bits read 0.
- R3: With ratio code n, the first serial clock edge comes 2^n reference cycles after `launch` and the edges follow every 2^n cycles, which gives a period of 2^(n+1) cycles. A frame has exactly 2*FRAME_BITS edges.
- R4: Outside a frame `sclk` equals bit 1 of the control word, and every frame ends with `sclk` back at that level.
- R5: With phase 0, `sample_stb` pulses on odd edges and `shift_stb` pulses on even edges except the last. With phase 1, `shift_stb` pulses on odd edges and `sample_stb` pulses on even edges. A strobe is high only in the cycle in which `sclk` has just toggled, and the two strobes are never high together.
- R6: With the override clear, `cs_n` goes low in the same cycle as `launch` and `active`. It goes high in the same cycle that `active` falls, which is the cycle of the last edge.
- R7: With the override bit set, `cs_n` follows the select value bit (0 selects the device) from the second cycle after the write, and frames do not move it.
- R8: In held-start mode, pending data alone does not start a frame. Writing 1 to the start bit while data is pending raises `launch` and `active` in the second cycle after the write cycle.
- R9: Outside held-start mode, a frame starts in the cycle after `tx_avail` is seen while idle with enable set. With enable 0 nothing starts, `cs_n` stays 1 and `sclk` stays at the idle level.
- R10: A ratio code written during a frame leaves that frame's edge spacing unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Control word write strobe |
| cfg_wdata | input | CFG_W | Control word write value |
| cfg_rdata | output | CFG_W | Control word read value |
| tx_avail | input | 1 | Queue holds data for the next frame |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Device select, active low |
| active | output | 1 | Frame in progress |
| launch | output | 1 | One-cycle pulse when a frame starts |
| shift_stb | output | 1 | Present the next outgoing bit |
| sample_stb | output | 1 | Capture the incoming bit |

## Verification
The hardest case to reach from the ports is a ratio change that lands in the middle of a running frame, because the write must arrive while the edge counter is partway through. The bench counts reference cycles from `launch` and writes a new code on the third cycle of a slow frame. It then checks that every edge of that frame keeps the old spacing. Held-start mode is reached by keeping `tx_avail` high for many cycles with no start command and confirming that nothing starts, before the start bit is written.

// File: rtl/sclkgen_pkg.sv
package sclkgen_pkg;
   localparam int DIV_W    = 3;
   localparam int POS_MEN  = 0;
   localparam int POS_POL  = 1;
   localparam int POS_PHA  = 2;
   localparam int POS_DIV  = 3;
   localparam int POS_CSV  = 10;
   localparam int POS_CSF  = 14;
   localparam int POS_MAN  = 15;
   localparam int POS_GO   = 16;
   localparam int FIELD_W  = POS_GO + 1;

   typedef struct packed {
      logic             man_en;
      logic             cs_force;
      logic             cs_val;
      logic [DIV_W-1:0] div;
      logic             pha;
      logic             pol;
      logic             men;
   } ctrl_t;

   function automatic ctrl_t ctrl_decode(input logic [FIELD_W-1:0] w);
      ctrl_t c;
      c.men      = w[POS_MEN];
      c.pol      = w[POS_POL];
      c.pha      = w[POS_PHA];
      c.div      = w[POS_DIV +: DIV_W];
      c.cs_val   = w[POS_CSV];
      c.cs_force = w[POS_CSF];
      c.man_en   = w[POS_MAN];
      return c;
   endfunction

   function automatic logic [FIELD_W-1:0] ctrl_encode(input ctrl_t c);
      logic [FIELD_W-1:0] w;
      w                  = '0;
      w[POS_MEN]         = c.men;
      w[POS_POL]         = c.pol;
      w[POS_PHA]         = c.pha;
      w[POS_DIV +: DIV_W] = c.div;
      w[POS_CSV]         = c.cs_val;
      w[POS_CSF]         = c.cs_force;
      w[POS_MAN]         = c.man_en;
      return w;
   endfunction
endpackage

// File: rtl/sclkgen_cfg.sv
module sclkgen_cfg
   import sclkgen_pkg::*;
#(
   parameter int CFG_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [CFG_W-1:0] wr_data,
   output ctrl_t            ctrl,
   output logic [CFG_W-1:0] rd_data,
   output logic             go_pulse
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl     <= '0;
         go_pulse <= 1'b0;
      end else begin
         go_pulse <= wr_en & wr_data[POS_GO];
         if (wr_en) ctrl <= ctrl_decode(wr_data[FIELD_W-1:0]);
      end
   end

   assign rd_data = CFG_W'(ctrl_encode(ctrl));
endmodule

// File: rtl/sclkgen_div.sv
module sclkgen_div
   import sclkgen_pkg::*;
#(
   parameter int CODE_W = DIV_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              load_ok,
   input  logic [CODE_W-1:0] code,
   output logic              tick
);
   localparam int CNT_W = (1 << CODE_W) - 1;

   logic [CODE_W-1:0] code_act;
   logic [CNT_W-1:0]  cnt;
   logic [CNT_W:0]    span;
   logic [CNT_W-1:0]  half_m1;

   assign span    = (CNT_W+1)'(1) << code_act;
   assign half_m1 = CNT_W'(span - 1'b1);
   assign tick    = run && (cnt == half_m1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_act <= '0;
         cnt      <= '0;
      end else begin
         if (load_ok) code_act <= code;
         if (!run || tick) cnt <= '0;
         else              cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/sclkgen_edges.sv
module sclkgen_edges #(
   parameter int FRAME_BITS = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic tick,
   input  logic cpol,
   input  logic cpha,
   input  logic cs_force,
   input  logic cs_val,
   output logic sclk,
   output logic cs_n,
   output logic active,
   output logic launch,
   output logic shift_stb,
   output logic sample_stb
);
   localparam int EDGES = 2 * FRAME_BITS;
   localparam int EW    = $clog2(EDGES + 1);

   logic [EW-1:0] edge_cnt;
   logic [EW-1:0] k;
   logic          last;
   logic          odd;
   logic          busy_nx;

   assign k       = edge_cnt + 1'b1;
   assign last    = tick && (k == EW'(EDGES));
   assign odd     = k[0];
   assign busy_nx = active ? !last : start;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active     <= 1'b0;
         launch     <= 1'b0;
         sclk       <= 1'b0;
         cs_n       <= 1'b1;
         edge_cnt   <= '0;
         shift_stb  <= 1'b0;
         sample_stb <= 1'b0;
      end else begin
         active <= busy_nx;
         launch <= start && !active;
         if (!active) begin
            sclk     <= cpol;
            edge_cnt <= '0;
         end else if (tick) begin
            sclk     <= ~sclk;
            edge_cnt <= last ? '0 : k;
         end
         shift_stb  <= tick && (cpha ? odd : (!odd && !last));
         sample_stb <= tick && (cpha ? !odd : odd);
         cs_n       <= cs_force ? cs_val : !busy_nx;
      end
   end
endmodule

// File: rtl/sclk_cs_gen.sv
module sclk_cs_gen
   import sclkgen_pkg::*;
#(
   parameter int CFG_W      = 32,
   parameter int FRAME_BITS = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_wr,
   input  logic [CFG_W-1:0] cfg_wdata,
   output logic [CFG_W-1:0] cfg_rdata,
   input  logic             tx_avail,
   output logic             sclk,
   output logic             cs_n,
   output logic             active,
   output logic             launch,
   output logic             shift_stb,
   output logic             sample_stb
);
   generate
      if (CFG_W < FIELD_W) begin : g_bad_cfg
         $error("CFG_W too narrow for the control fields");
      end
      if (FRAME_BITS < 2 || FRAME_BITS > 64) begin : g_bad_frame
         $error("FRAME_BITS out of range");
      end
   endgenerate

   ctrl_t ctrl;
   logic  go_pulse;
   logic  tick;
   logic  start;
   logic  load_ok;

   sclkgen_cfg #(.CFG_W(CFG_W)) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (cfg_wr),
      .wr_data  (cfg_wdata),
      .ctrl     (ctrl),
      .rd_data  (cfg_rdata),
      .go_pulse (go_pulse)
   );

   assign start   = !active && ctrl.men && tx_avail && (ctrl.man_en ? go_pulse : 1'b1);
   assign load_ok = !active && cs_n;

   sclkgen_div #(.CODE_W(DIV_W)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (active),
      .load_ok (load_ok),
      .code    (ctrl.div),
      .tick    (tick)
   );

   sclkgen_edges #(.FRAME_BITS(FRAME_BITS)) u_edges (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .tick       (tick),
      .cpol       (ctrl.pol),
      .cpha       (ctrl.pha),
      .cs_force   (ctrl.cs_force),
      .cs_val     (ctrl.cs_val),
      .sclk       (sclk),
      .cs_n       (cs_n),
      .active     (active),
      .launch     (launch),
      .shift_stb  (shift_stb),
      .sample_stb (sample_stb)
   );
endmodule

// File: rtl/sclk_cs_gen_chk.sv
module sclk_cs_gen_chk #(
   parameter int CFG_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic [CFG_W-1:0] cfg_rdata,
   input logic             sclk,
   input logic             cs_n,
   input logic             active,
   input logic             launch,
   input logic             shift_stb,
   input logic             sample_stb
);
   // R4
   idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(active) |-> (sclk == $past(cfg_rdata[1])));

   // R5
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(shift_stb && sample_stb));

   // R5
   strobe_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_stb || sample_stb) |-> (sclk != $past(sclk)));

   // R6
   cs_auto_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(cfg_rdata[14]) |-> (cs_n == !active));

   // R7
   cs_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cfg_rdata[14]) |-> (cs_n == $past(cfg_rdata[10])));

   // R9
   launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      launch |-> (active && !$past(active) && $past(cfg_rdata[0])));
endmodule

bind sclk_cs_gen sclk_cs_gen_chk #(.CFG_W(CFG_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cfg_rdata  (cfg_rdata),
   .sclk       (sclk),
   .cs_n       (cs_n),
   .active     (active),
   .launch     (launch),
   .shift_stb  (shift_stb),
   .sample_stb (sample_stb)
);

// File: tb/sclk_cs_gen_test.sv
module sclk_cs_gen_test;
   localparam int CFG_W = 32;
   localparam int NB    = 8;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cfg_wr = 1'b0;
   logic [CFG_W-1:0] cfg_wdata = '0;
   logic [CFG_W-1:0] cfg_rdata;
   logic             tx_avail = 1'b0;
   logic             sclk, cs_n, active, launch, shift_stb, sample_stb;

   int checks = 0;
   int fails  = 0;

   always #5 clk = ~clk;

   sclk_cs_gen #(.CFG_W(CFG_W), .FRAME_BITS(NB)) uut (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .tx_avail(tx_avail), .sclk(sclk), .cs_n(cs_n),
      .active(active), .launch(launch), .shift_stb(shift_stb),
      .sample_stb(sample_stb));

   // {code[2:0], cpol, cpha}
   localparam logic [4:0] VEC [6] = '{
      {3'd0, 1'b0, 1'b0}, {3'd1, 1'b0, 1'b1}, {3'd2, 1'b1, 1'b0},
      {3'd3, 1'b1, 1'b1}, {3'd0, 1'b1, 1'b1}, {3'd7, 1'b0, 1'b0}};

   task automatic chk(input bit ok, input string req, input int act,
                      input int exp, input string what);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic wr_cfg(input logic [CFG_W-1:0] d);
      @(negedge clk);
      cfg_wr = 1'b1;
      cfg_wdata = d;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   function automatic logic [CFG_W-1:0] word(input logic [2:0] code,
      input logic pol, input logic pha, input logic men);
      return CFG_W'({code, pha, pol, men});
   endfunction

   task automatic run_frame(input logic [2:0] code, input logic pol,
      input logic pha, input bit mid, input logic [2:0] mid_code);
      int h, last_t, edges, nsamp, nshift, bad_time, bad_stb, bad_cs;
      logic prev;
      bit got;
      h = 1 << code;
      last_t = 2 * NB * h;
      wr_cfg(word(code, pol, pha, 1'b1));
      repeat (3) @(negedge clk);
      chk(sclk == pol, "R4", sclk, pol, "idle level before frame");
      tx_avail = 1'b1;
      got = 0;
      for (int i = 0; i < 50 && !got; i++) begin
         @(negedge clk);
         if (launch) got = 1;
      end
      tx_avail = 1'b0;
      chk(got && cs_n == 1'b0, "R6", cs_n, 0, "select low at launch");
      prev = sclk; edges = 0; nsamp = 0; nshift = 0;
      bad_time = 0; bad_stb = 0; bad_cs = 0;
      for (int t = 1; t <= last_t; t++) begin
         bit ch, exp_ch, odd;
         @(negedge clk);
         ch = (sclk != prev);
         exp_ch = (t % h) == 0;
         if (ch != exp_ch) bad_time++;
         if (ch) begin
            edges++;
            odd = edges[0];
            if (pha == 1'b0) begin
               if (sample_stb != odd) bad_stb++;
               if (shift_stb != (!odd && edges != 2 * NB)) bad_stb++;
            end else begin
               if (shift_stb != odd) bad_stb++;
               if (sample_stb != !odd) bad_stb++;
            end
         end else if (shift_stb || sample_stb) bad_stb++;
         nsamp += int'(sample_stb);
         nshift += int'(shift_stb);
         if (t < last_t) begin
            if (cs_n != 1'b0 || active != 1'b1) bad_cs++;
         end else begin
            if (cs_n != 1'b1 || active != 1'b0) bad_cs++;
         end
         prev = sclk;
         if (mid && t == 3) begin
            cfg_wr = 1'b1;
            cfg_wdata = word(mid_code, pol, pha, 1'b1);
         end
         if (mid && t == 4) cfg_wr = 1'b0;
      end
      chk(bad_time == 0, mid ? "R10" : "R3", bad_time, 0, "edge spacing errors");
      chk(edges == 2 * NB, "R3", edges, 2 * NB, "edges per frame");
      chk(sclk == pol, "R4", sclk, pol, "level after frame");
      chk(bad_stb == 0 && nsamp == NB, "R5", nsamp, NB, "sample strobes");
      chk(nshift == (pha ? NB : NB - 1), "R5", nshift, pha ? NB : NB - 1,
          "shift strobes");
      chk(bad_cs == 0, "R6", bad_cs, 0, "select/active window errors");
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      bit got;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(sclk == 1'b0, "R1", sclk, 0, "sclk in reset");
      chk(cs_n == 1'b1, "R1", cs_n, 1, "cs_n in reset");
      chk({active, launch, shift_stb, sample_stb} == 4'b0, "R1",
          {active, launch, shift_stb, sample_stb}, 0, "status in reset");
      chk(cfg_rdata == '0, "R1", cfg_rdata, 0, "readback in reset");
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R2 readback, start bit reads 0
      wr_cfg(32'hFFFF_FFFF);
      chk(cfg_rdata == 32'h0000_C43F, "R2", cfg_rdata, 32'h0000_C43F, "field readback");
      wr_cfg(32'h0000_0000);
      chk(cfg_rdata == '0, "R2", cfg_rdata, 0, "cleared readback");

      // R3 R4 R5 R6 vector table
      for (int i = 0; i < 6; i++)
         run_frame(VEC[i][4:2], VEC[i][1], VEC[i][0], 1'b0, 3'd0);

      // R10 ratio written mid-frame
      run_frame(3'd1, 1'b0, 1'b0, 1'b1, 3'd0);
      chk(cfg_rdata[5:3] == 3'd0, "R10", cfg_rdata[5:3], 0, "new code stored");

      // R9 enable clear blocks frames
      wr_cfg(word(3'd0, 1'b1, 1'b0, 1'b0));
      tx_avail = 1'b1;
      repeat (20) @(negedge clk);
      chk(active == 1'b0 && cs_n == 1'b1, "R9", active, 0, "no frame while disabled");
      chk(sclk == 1'b1, "R9", sclk, 1, "idle level while disabled");
      tx_avail = 1'b0;

      // R8 held start
      wr_cfg(32'h0000_8001);
      tx_avail = 1'b1;
      repeat (12) @(negedge clk);
      chk(active == 1'b0 && cs_n == 1'b1, "R8", active, 0, "pending data held");
      wr_cfg(32'h0001_8001);
      chk(active == 1'b0 && launch == 1'b0, "R8", active, 0, "not yet started");
      @(negedge clk);
      chk(launch == 1'b1 && active == 1'b1, "R8", launch, 1, "launch after start bit");
      chk(cfg_rdata[16] == 1'b0, "R8", cfg_rdata[16], 0, "start bit reads 0");
      tx_avail = 1'b0;
      got = 0;
      for (int i = 0; i < 100 && !got; i++) begin
         @(negedge clk);
         if (!active) got = 1;
      end
      chk(got, "R8", active, 0, "held-start frame completes");

      // R7 select override
      wr_cfg(32'h0000_4001);
      @(negedge clk);
      chk(cs_n == 1'b0, "R7", cs_n, 0, "override selects");
      tx_avail = 1'b1;
      got = 0;
      for (int i = 0; i < 20 && !got; i++) begin
         @(negedge clk);
         if (launch) got = 1;
      end
      tx_avail = 1'b0;
      chk(got, "R9", launch, 1, "auto frame starts on pending data");
      got = 0;
      for (int i = 0; i < 100 && !got; i++) begin
         @(negedge clk);
         if (!active) got = 1;
      end
      @(negedge clk);
      chk(got && cs_n == 1'b0, "R7", cs_n, 0, "override holds after frame");
      wr_cfg(32'h0000_4401);
      @(negedge clk);
      chk(cs_n == 1'b1, "R7", cs_n, 1, "override deselects");
      wr_cfg(32'h0000_0001);
      @(negedge clk);
      chk(cs_n == 1'b1 && active == 1'b0, "R6", cs_n, 1, "released select idle high");

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule